// File: doc/BRIEF.md
# Branch and Predicated-Execution Unit

This block resolves control flow for a small 8-bit core that uses 16-bit instruction words. For each instruction the pipeline presents, it works out the next program counter. It decides whether the return-address register must be loaded, and with which value. It also reports whether the instruction has to be discarded.

The block handles absolute jump-and-link, PC-relative branches (unconditional, on zero, on non-zero), returns (unconditional, on carry, on zero) and indirect call/jump through the index register. A two-bit predicate register is loaded by three predicate-setting instructions and then moves along one step per instruction. Bit 0 of the predicate decides whether the current instruction executes. Bit 1 decides the same for the instruction after it. The predicate can be read out so it can be saved with the return address, and it can be written back later.

All results are registered. They appear one clock after the instruction is presented with its valid strobe. Clock cycles without a valid instruction leave the predicate untouched.

Top module: `branch_pred_unit`

## Requirements
- R1: Synchronous active-high reset clears `res_valid`, `res_redirect`, `ra_we` and `res_squash`, and sets `pred_state` to 2'b11.
- R2: A word with bit 15 clear is a jump-and-link. On the next clock, `res_next_pc` = instr[14:0], `res_redirect`=1, `ra_we`=1 and `ra_wdata` = pc+1.
- R3: Relative branches set the target to pc plus the sign-extended instr[10:0]. A word with instr[15:11]=10110 always branches. A word with 10111 branches only when Z=1. A word with 10101 branches only when Z=0.
- R4: instr[15:7]=100010100 returns to `ra`. 100010110 returns to `ra` only when carry=1. 100010111 returns to `ra` only when Z=1.
- R5: instr[15:5]=10001010100 jumps to `ix` and links (`ra_we`=1, `ra_wdata`=pc+1). instr[15:5]=10001010101 jumps to `ix` without linking.
- R6: The condition code in instr[2:0] tests the flags as follows. 0: Z. 1: !Z. 2: !C. 3: C. 4: !S&!Z. 5: S&!Z. 6: !S|Z. 7: S|Z. Here S is the signed-less-than flag.
- R7: The word 1010_0010_0000_0ccc sets the predicate to {1, test}, so only the next instruction is conditional.
- R8: 1010_0010_0000_1ccc sets the predicate to {test, test}. 1010_0010_0001_0ccc sets it to {!test, test}.
- R9: After every presented instruction, the predicate shifts: bit 0 takes bit 1, and bit 1 becomes 1. An instruction presented while bit 0 is 0 gets `res_squash`=1. It then produces no redirect and no RA load, and if it is a predicate-setting word it does not set the predicate.
- R10: An executed instruction presented with `pred_restore_en`=1 loads `pred_state` with `pred_restore_val`. The restored value governs the next instruction onward.
- R11: Any other word, and any branch or return whose condition fails, gives `res_redirect`=0 and `res_next_pc` = pc+1.
- R12: `res_valid` is 1 exactly on the clock after `instr_valid`. Cycles without `instr_valid` leave the predicate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| pc | input | PC_W | Address of the presented instruction |
| ra | input | PC_W | Current return-address register |
| ix | input | PC_W | Current index register |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Signed-less-than flag |
| pred_restore_en | input | 1 | Load the predicate from `pred_restore_val` |
| pred_restore_val | input | 2 | Predicate value to restore |
| pred_state | output | 2 | Current predicate register |
| res_valid | output | 1 | Results below belong to the previous instruction |
| res_squash | output | 1 | That instruction was discarded |
| res_redirect | output | 1 | Control flow leaves the sequential path |
| res_next_pc | output | PC_W | Next program counter |
| ra_we | output | 1 | Load the return-address register |
| ra_wdata | output | PC_W | Value for the return-address register |

## Verification
On every cycle, the assertions check these rules:
- A squashed result never redirects or links.
- A link value is always the presented PC plus one.
- A non-redirecting result always points to the next sequential address.
- `res_valid` tracks the strobe.
- The predicate holds through idle cycles, and shifts in a 1 whenever nothing sets or restores it.

Only the bench scenarios can show the rest: that each opcode and condition code selects the right target, and that the three predicate-setting forms govern exactly the next one or two instructions. The same goes for a squashed predicate-setting word leaving the predicate alone, and for a restored predicate taking hold from the following instruction.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_JAL,
    OP_BR,
    OP_BZ,
    OP_BNZ,
    OP_RET,
    OP_RC,
    OP_RZ,
    OP_CALLIX,
    OP_JMPIX,
    OP_PSET1,
    OP_PSETTT,
    OP_PSETTE
  } bpu_op_e;

  localparam int INSTR_W = 16;
  localparam int PRED_W  = 2;
  localparam int CC_W    = 3;
  localparam int REL_W   = 11;
  localparam int JAL_W   = 15;

endpackage

// File: rtl/bpu_decode.sv
module bpu_decode
  import bpu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output bpu_op_e            op_o,
  output logic [CC_W-1:0]    cc_o
);

  always_comb begin
    op_o = OP_NONE;
    cc_o = instr_i[CC_W-1:0];
    if (!instr_i[15])                           op_o = OP_JAL;
    else if (instr_i[15:11] == 5'b10110)        op_o = OP_BR;
    else if (instr_i[15:11] == 5'b10111)        op_o = OP_BZ;
    else if (instr_i[15:11] == 5'b10101)        op_o = OP_BNZ;
    else if (instr_i[15:7]  == 9'b1000_1010_0)  op_o = OP_RET;
    else if (instr_i[15:7]  == 9'b1000_1011_0)  op_o = OP_RC;
    else if (instr_i[15:7]  == 9'b1000_1011_1)  op_o = OP_RZ;
    else if (instr_i[15:5]  == 11'b1000_1010_100) op_o = OP_CALLIX;
    else if (instr_i[15:5]  == 11'b1000_1010_101) op_o = OP_JMPIX;
    else if (instr_i[15:3]  == 13'b1010_0010_0000_0) op_o = OP_PSET1;
    else if (instr_i[15:3]  == 13'b1010_0010_0000_1) op_o = OP_PSETTT;
    else if (instr_i[15:3]  == 13'b1010_0010_0001_0) op_o = OP_PSETTE;
  end

endmodule

// File: rtl/bpu_cond_eval.sv
module bpu_cond_eval
  import bpu_pkg::*;
(
  input  logic [CC_W-1:0] cc_i,
  input  logic            z_i,
  input  logic            c_i,
  input  logic            s_i,
  output logic            pass_o
);

  always_comb begin
    unique case (cc_i)
      3'd0: pass_o = z_i;
      3'd1: pass_o = !z_i;
      3'd2: pass_o = !c_i;
      3'd3: pass_o = c_i;
      3'd4: pass_o = !s_i && !z_i;
      3'd5: pass_o = s_i && !z_i;
      3'd6: pass_o = !s_i || z_i;
      default: pass_o = s_i || z_i;
    endcase
  end

endmodule

// File: rtl/bpu_pred_reg.sv
module bpu_pred_reg
  import bpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              set_en_i,
  input  logic [PRED_W-1:0] set_val_i,
  input  logic              load_en_i,
  input  logic [PRED_W-1:0] load_val_i,
  output logic [PRED_W-1:0] pred_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_o <= '1;
    end else if (step_i) begin
      if (set_en_i)       pred_o <= set_val_i;
      else if (load_en_i) pred_o <= load_val_i;
      else                pred_o <= {1'b1, pred_o[PRED_W-1:1]};
    end
  end

  AST_PRED_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(pred_o)); // R12

  AST_PRED_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    (step_i && !set_en_i && !load_en_i) |=> pred_o[PRED_W-1]); // R9

endmodule

// File: rtl/branch_pred_unit.sv
module branch_pred_unit
  import bpu_pkg::*;
#(
  parameter int PC_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [PC_W-1:0]     pc,
  input  logic [PC_W-1:0]     ra,
  input  logic [PC_W-1:0]     ix,
  input  logic                flag_z,
  input  logic                flag_c,
  input  logic                flag_s,
  input  logic                pred_restore_en,
  input  logic [PRED_W-1:0]   pred_restore_val,
  output logic [PRED_W-1:0]   pred_state,
  output logic                res_valid,
  output logic                res_squash,
  output logic                res_redirect,
  output logic [PC_W-1:0]     res_next_pc,
  output logic                ra_we,
  output logic [PC_W-1:0]     ra_wdata
);

  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  bpu_op_e         op;
  logic [CC_W-1:0] cc;
  logic            test;
  logic            exec;
  logic            is_pset;
  logic [PRED_W-1:0] pset_val;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] tgt;
  logic            take;
  logic            link;

  bpu_decode u_dec (
    .instr_i (instr),
    .op_o    (op),
    .cc_o    (cc)
  );

  bpu_cond_eval u_cond (
    .cc_i   (cc),
    .z_i    (flag_z),
    .c_i    (flag_c),
    .s_i    (flag_s),
    .pass_o (test)
  );

  assign exec   = instr_valid && pred_state[0];
  assign seq_pc = pc + ONE;
  assign rel_pc = pc + PC_W'($signed(instr[REL_W-1:0]));

  always_comb begin
    is_pset  = 1'b0;
    pset_val = '1;
    unique case (op)
      OP_PSET1:  begin is_pset = 1'b1; pset_val = {1'b1, test};  end
      OP_PSETTT: begin is_pset = 1'b1; pset_val = {test, test};  end
      OP_PSETTE: begin is_pset = 1'b1; pset_val = {!test, test}; end
      default:   ;
    endcase
  end

  always_comb begin
    take = 1'b0;
    link = 1'b0;
    tgt  = seq_pc;
    unique case (op)
      OP_JAL:    begin take = 1'b1; link = 1'b1; tgt = PC_W'(instr[JAL_W-1:0]); end
      OP_BR:     begin take = 1'b1;        tgt = rel_pc; end
      OP_BZ:     begin take = flag_z;      tgt = rel_pc; end
      OP_BNZ:    begin take = !flag_z;     tgt = rel_pc; end
      OP_RET:    begin take = 1'b1;        tgt = ra; end
      OP_RC:     begin take = flag_c;      tgt = ra; end
      OP_RZ:     begin take = flag_z;      tgt = ra; end
      OP_CALLIX: begin take = 1'b1; link = 1'b1; tgt = ix; end
      OP_JMPIX:  begin take = 1'b1;        tgt = ix; end
      default:   ;
    endcase
  end

  bpu_pred_reg u_pred (
    .clk        (clk),
    .rst        (rst),
    .step_i     (instr_valid),
    .set_en_i   (exec && is_pset),
    .set_val_i  (pset_val),
    .load_en_i  (exec && pred_restore_en),
    .load_val_i (pred_restore_val),
    .pred_o     (pred_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_squash   <= 1'b0;
      res_redirect <= 1'b0;
      res_next_pc  <= '0;
      ra_we        <= 1'b0;
      ra_wdata     <= '0;
    end else begin
      res_valid    <= instr_valid;
      res_squash   <= instr_valid && !pred_state[0];
      res_redirect <= exec && take;
      ra_we        <= exec && link;
      if (instr_valid) begin
        res_next_pc <= (exec && take) ? tgt : seq_pc;
        ra_wdata    <= seq_pc;
      end
    end
  end

  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (rst)
    res_squash |-> (!res_redirect && !ra_we)); // R9

  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst)
    ra_we |-> (ra_wdata == $past(pc) + ONE)); // R2

  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_redirect) |-> (res_next_pc == $past(pc) + ONE)); // R11

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> res_valid); // R12

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !res_valid); // R12

endmodule

// File: tb/test_branch_pred_unit.sv
module test_branch_pred_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 15;

  logic clk = 1'b0;
  logic rst;
  logic instr_valid;
  logic [15:0] instr;
  logic [PC_W-1:0] pc, ra, ix;
  logic fz, fc, fs;
  logic rs_en;
  logic [1:0] rs_val;
  logic [1:0] pred_state;
  logic res_valid, res_squash, res_redirect, ra_we;
  logic [PC_W-1:0] res_next_pc, ra_wdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_pred_unit #(.PC_W(PC_W)) i_branch_pred_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .pc(pc), .ra(ra), .ix(ix), .flag_z(fz), .flag_c(fc), .flag_s(fs),
    .pred_restore_en(rs_en), .pred_restore_val(rs_val),
    .pred_state(pred_state), .res_valid(res_valid), .res_squash(res_squash),
    .res_redirect(res_redirect), .res_next_pc(res_next_pc),
    .ra_we(ra_we), .ra_wdata(ra_wdata)
  );

  typedef struct packed {
    logic [15:0]     ins;
    logic            z, c, s;
    logic [PC_W-1:0] npc;
    logic            redir, rawe;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 1'b0, 1'b0, 1'b0, 15'h1234, 1'b1, 1'b1},  // R2
    '{16'h7FFF, 1'b1, 1'b1, 1'b1, 15'h7FFF, 1'b1, 1'b1},  // R2
    '{16'hB005, 1'b0, 1'b0, 1'b0, 15'h0105, 1'b1, 1'b0},  // R3
    '{16'hB7FE, 1'b0, 1'b0, 1'b0, 15'h00FE, 1'b1, 1'b0},  // R3
    '{16'hB810, 1'b1, 1'b0, 1'b0, 15'h0110, 1'b1, 1'b0},  // R3
    '{16'hB810, 1'b0, 1'b0, 1'b0, 15'h0101, 1'b0, 1'b0},  // R3
    '{16'hA820, 1'b0, 1'b0, 1'b0, 15'h0120, 1'b1, 1'b0},  // R3
    '{16'hA820, 1'b1, 1'b0, 1'b0, 15'h0101, 1'b0, 1'b0},  // R3
    '{16'h8A00, 1'b0, 1'b0, 1'b0, 15'h0456, 1'b1, 1'b0},  // R4
    '{16'h8B00, 1'b0, 1'b1, 1'b0, 15'h0456, 1'b1, 1'b0},  // R4
    '{16'h8B00, 1'b1, 1'b0, 1'b0, 15'h0101, 1'b0, 1'b0},  // R4
    '{16'h8B80, 1'b1, 1'b0, 1'b0, 15'h0456, 1'b1, 1'b0},  // R4
    '{16'h8B80, 1'b0, 1'b1, 1'b0, 15'h0101, 1'b0, 1'b0},  // R4
    '{16'h8A80, 1'b0, 1'b0, 1'b0, 15'h0789, 1'b1, 1'b1},  // R5
    '{16'h8AA0, 1'b0, 1'b0, 1'b0, 15'h0789, 1'b1, 1'b0},  // R5
    '{16'h9123, 1'b1, 1'b1, 1'b1, 15'h0101, 1'b0, 1'b0},  // R11
    '{16'hF000, 1'b0, 1'b0, 1'b0, 15'h0101, 1'b0, 1'b0}   // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic cc_ref(input int cc, input logic z, input logic c, input logic s);
    case (cc)
      0: return z;
      1: return !z;
      2: return !c;
      3: return c;
      4: return !s && !z;
      5: return s && !z;
      6: return !s || z;
      default: return s || z;
    endcase
  endfunction

  // called at a falling edge; returns at the next falling edge with results visible
  task automatic issue(input logic [15:0] w, input logic z, input logic c, input logic s,
                       input logic ren, input logic [1:0] rval);
    instr = w; fz = z; fc = c; fs = s; rs_en = ren; rs_val = rval;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    rs_en = 1'b0;
  endtask

  task automatic idle();
    instr_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = '0;
    pc = 15'h0100; ra = 15'h0456; ix = 15'h0789;
    fz = 0; fc = 0; fs = 0; rs_en = 0; rs_val = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid", res_valid, 0);
    chk("R1 redirect", res_redirect, 0);
    chk("R1 ra_we", ra_we, 0);
    chk("R1 squash", res_squash, 0);
    chk("R1 pred", pred_state, 2'b11);
    rst = 1'b0;
    @(negedge clk);

    // table of control-flow vectors (predicate stays 11)
    for (int k = 0; k < NV; k++) begin
      issue(VECS[k].ins, VECS[k].z, VECS[k].c, VECS[k].s, 1'b0, 2'b00);
      chk("R12 valid", res_valid, 1);
      chk("R2/R3/R4/R5/R11 next_pc", res_next_pc, VECS[k].npc);
      chk("R2/R3/R4/R5/R11 redirect", res_redirect, VECS[k].redir);
      chk("R2/R5 ra_we", ra_we, VECS[k].rawe);
      if (VECS[k].rawe) chk("R2 ra_wdata", ra_wdata, 15'h0101);
    end

    // R6 / R7: every condition code against every flag combination
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 8; f++) begin
        logic t;
        t = cc_ref(cc, f[2], f[1], f[0]);
        issue(16'hA200 | 16'(cc), f[2], f[1], f[0], 1'b0, 2'b00);
        chk("R7 pred after single-set", pred_state, {1'b1, t});
        issue(16'hB005, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R6 squash", res_squash, !t);
        chk("R6 redirect", res_redirect, t);
        chk("R9 shift to 11", pred_state, 2'b11);
      end
    end

    // R8: both-then form, true and false
    issue(16'hA208, 1'b1, 0, 0, 0, 0);  // EQ, Z=1 -> true
    chk("R8 tt true pred", pred_state, 2'b11);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R8 tt true 1st", res_redirect, 1);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R8 tt true 2nd", res_redirect, 1);
    issue(16'hA208, 1'b0, 0, 0, 0, 0);  // false
    chk("R8 tt false pred", pred_state, 2'b00);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R8 tt false 1st", res_squash, 1);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R8 tt false 2nd", res_squash, 1);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R9 third executes", res_redirect, 1);
    // then-else form
    issue(16'hA210, 1'b1, 0, 0, 0, 0);  // true
    chk("R8 te true pred", pred_state, 2'b01);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R8 te true then", res_squash, 0);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R8 te true else", res_squash, 1);
    issue(16'hA210, 1'b0, 0, 0, 0, 0);  // false
    chk("R8 te false pred", pred_state, 2'b10);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R8 te false then", res_squash, 1);
    issue(16'hB005, 0, 0, 0, 0, 0); chk("R8 te false else", res_redirect, 1);

    // R9: squashed predicate-setting word has no effect
    issue(16'hA200, 1'b0, 0, 0, 0, 0);  // EQ false -> pred 10
    issue(16'hA208, 1'b0, 0, 0, 0, 0);  // squashed; would set 00
    chk("R9 squashed pset flagged", res_squash, 1);
    chk("R9 squashed pset no effect", pred_state, 2'b11);
    issue(16'hB005, 0, 0, 0, 0, 0);
    chk("R9 follower executes", res_redirect, 1);
    // squashed jal: no link, no redirect
    issue(16'hA200, 1'b0, 0, 0, 0, 0);
    issue(16'h1234, 0, 0, 0, 0, 0);
    chk("R9 squashed jal redirect", res_redirect, 0);
    chk("R9 squashed jal ra_we", ra_we, 0);
    chk("R9 squashed jal next_pc", res_next_pc, 15'h0101);

    // R12: idle cycles hold predicate
    issue(16'hA200, 1'b0, 0, 0, 0, 0);
    idle();
    chk("R12 idle valid low", res_valid, 0);
    idle();
    chk("R12 idle pred held", pred_state, 2'b10);
    issue(16'hB005, 0, 0, 0, 0, 0);
    chk("R12 still squashed after idle", res_squash, 1);

    // R10: restore takes effect from next instruction
    issue(16'h9000, 0, 0, 0, 1'b1, 2'b10);
    chk("R10 restoring word executes", res_squash, 0);
    chk("R10 pred restored", pred_state, 2'b10);
    issue(16'hB005, 0, 0, 0, 0, 0);
    chk("R10 next squashed", res_squash, 1);
    issue(16'hB005, 0, 0, 0, 0, 0);
    chk("R10 following executes", res_redirect, 1);
    // restore on a squashed word is ignored
    issue(16'hA200, 1'b0, 0, 0, 0, 0);
    issue(16'h9000, 0, 0, 0, 1'b1, 2'b00);
    chk("R10 squashed restore ignored", pred_state, 2'b11);

    // R1: reset mid-run
    issue(16'hA208, 1'b0, 0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset pred", pred_state, 2'b11);
    chk("R1 reset valid", res_valid, 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule